// File: doc/BRIEF.md
# Redirected Interrupt Request Dispatcher

This block sits between a bank of interrupt input lines and a message fabric that carries interrupts to processors. Each input pin has a 64-bit redirection entry, supplied from outside by the register file. The entry says how the pin is sensed (edge or level), whether it is masked, and what message to send. The block keeps one pending bit per pin. It picks the lowest-indexed pin that is pending and unmasked, and presents one message at a time on a valid/ready output. The message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode.

When an entry selects the external-interrupt delivery mode, the vector in the entry is ignored. The block first fetches a vector from a legacy interrupt controller through a request/acknowledge handshake, and only then presents the message. An override input can steer input line 0 onto pin 2. The block scans the pending register every cycle, so new requests and table changes are seen on the next scan.

The reset input is asserted asynchronously. Its release is synchronized inside the block with two flops, so the block leaves reset two clock edges after rst_n rises.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, msg_valid and ext_req are low and every pending bit is clear, so unmasking every entry with all lines low produces no message.
- R2: For a pin whose entry has bit 15 = 1 (level), a high input sets the pending bit and a low input clears it. A masked level pin whose line went low before unmasking sends nothing.
- R3: For a pin whose entry has bit 15 = 0 (edge), a rising input sets the pending bit. An input held high sets it only once, and a falling input does not clear it.
- R4: A pin whose entry has bit 16 = 1 (masked) is not delivered and stays pending. Clearing the mask in the table later delivers it.
- R5: Accepting a message for an edge pin clears that pin's pending bit. Accepting a message for a level pin leaves it pending, so the pin is delivered again while its line stays high.
- R6: When the entry's bits 10:8 equal 7, ext_req goes high and stays high until ext_ack is sampled high. The message vector is the ext_vector value captured with that acknowledge. msg_valid is never high while ext_req is high.
- R7: The message fields come from the entry: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, polarity from bit 13, trigger mode from bit 15, destination from bits 63:56. All fields stay stable while msg_valid is high and msg_ready is low.
- R8: When several pins are deliverable, messages go out in ascending pin index order.
- R9: With irq0_remap high, input line 0 drives pin 2 (ORed with line 2) and pin 0 sees no request. With irq0_remap low, line 0 drives pin 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_PINS | Interrupt input lines |
| irq0_remap | input | 1 | Steer line 0 onto pin 2 |
| route_tbl | input | NUM_PINS*64 | Redirection entries, pin i at bits 64*i+63 : 64*i |
| ext_req | output | 1 | Vector request to the legacy controller |
| ext_ack | input | 1 | Legacy controller acknowledge |
| ext_vector | input | 8 | Vector from the legacy controller, valid with ext_ack |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_level | output | 1 | Trigger mode, 1 = level |

## Verification
A pending bit left set by mistake shows up at the ports as a second message, two cycles after the previous one is accepted. A pending bit lost by mistake shows up as a missing message within two cycles of the line's rising edge. A wrong selection index shows up at once as the wrong vector or destination, because every pin in the sweep carries distinct field values. A fault in the fetch path shows up either as ext_req and msg_valid being high together, or as the table vector appearing where the fetched one was expected.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ENT_W   = 64;
  localparam int VEC_LO  = 0;
  localparam int DM_LO   = 8;
  localparam int DMODE_B = 11;
  localparam int POL_B   = 13;
  localparam int TRIG_B  = 15;
  localparam int MASK_B  = 16;
  localparam int DEST_LO = 56;
  localparam logic [2:0] DM_EXT = 3'd7;

  typedef struct packed {
    logic [7:0] dest;
    logic       dmode;
    logic [2:0] deliv;
    logic [7:0] vec;
    logic       pol;
    logic       lvl;
  } msg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} st_t;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lines,
  input  logic                remap,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] pend_q
);
  logic [NUM_PINS-1:0] pin_in, prev_q, rise, pend_d;

  // route line 0 onto pin 2 when the override is set
  always_comb begin
    pin_in = lines;
    if (remap) begin
      pin_in[0] = 1'b0;
      pin_in[2] = lines[2] | lines[0];
    end
  end

  assign rise = pin_in & ~prev_q;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (lvl_mode[i]) pend_d[i] = pin_in[i];
      else             pend_d[i] = (pend_q[i] & ~clr_vec[i]) | rise[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin_in;
      pend_q <= pend_d;
    end
  end

  logic [NUM_PINS-1:0] edge_keep;
  assign edge_keep = pend_q & ~lvl_mode & ~clr_vec;

  assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(edge_keep)) == $past(edge_keep)));

  assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] req,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_msg_fsm.sv
module irq_msg_fsm
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [IDX_W-1:0]    hit_idx,
  input  msg_t                sel_fields,
  output logic                ext_req,
  input  logic                ext_ack,
  input  logic [7:0]          ext_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output msg_t                msg,
  output logic [NUM_PINS-1:0] clr_vec
);
  st_t              st_q, st_d;
  msg_t             msg_q, msg_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept;

  always_comb begin
    st_d  = st_q;
    msg_d = msg_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: if (hit) begin
        idx_d = hit_idx;
        msg_d = sel_fields;
        st_d  = (sel_fields.deliv == DM_EXT) ? ST_FETCH : ST_SEND;
      end
      ST_FETCH: if (ext_ack) begin
        msg_d.vec = ext_vector;
        st_d      = ST_SEND;
      end
      ST_SEND: if (msg_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      msg_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      msg_q <= msg_d;
      idx_q <= idx_d;
    end
  end

  assign msg_valid = (st_q == ST_SEND);
  assign ext_req   = (st_q == ST_FETCH);
  assign msg       = msg_q;
  assign accept    = msg_valid & msg_ready;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_clr
    assign clr_vec[i] = accept & ~msg_q.lvl & (idx_q == IDX_W'(i));
  end

  assert_msg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg)));

  assert_fetch_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> ext_req);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_req && msg_valid));

  assert_fetch_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (msg_valid && msg.vec == $past(ext_vector)));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       irq_lines,
  input  logic                      irq0_remap,
  input  logic [NUM_PINS*ENT_W-1:0] route_tbl,
  output logic                      ext_req,
  input  logic                      ext_ack,
  input  logic [7:0]                ext_vector,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [7:0]                msg_dest,
  output logic                      msg_dest_mode,
  output logic [2:0]                msg_deliv,
  output logic [7:0]                msg_vector,
  output logic                      msg_polarity,
  output logic                      msg_level
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_PINS-1:0][ENT_W-1:0] tbl_arr;
  logic [NUM_PINS-1:0]            lvl_vec, mask_vec, unused_spare;
  msg_t [NUM_PINS-1:0]            fields;
  assign tbl_arr = route_tbl;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    assign lvl_vec[i]      = tbl_arr[i][TRIG_B];
    assign mask_vec[i]     = tbl_arr[i][MASK_B];
    assign fields[i].dest  = tbl_arr[i][DEST_LO +: 8];
    assign fields[i].dmode = tbl_arr[i][DMODE_B];
    assign fields[i].deliv = tbl_arr[i][DM_LO +: 3];
    assign fields[i].vec   = tbl_arr[i][VEC_LO +: 8];
    assign fields[i].pol   = tbl_arr[i][POL_B];
    assign fields[i].lvl   = tbl_arr[i][TRIG_B];
    assign unused_spare[i] = ^{tbl_arr[i][12], tbl_arr[i][14], tbl_arr[i][DEST_LO-1:MASK_B+1]};
  end

  logic [NUM_PINS-1:0] pend, clr_vec;
  logic                hit;
  logic [IDX_W-1:0]    hit_idx;
  msg_t                msg;

  irq_pend_reg #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .lines(irq_lines), .remap(irq0_remap),
    .lvl_mode(lvl_vec), .clr_vec(clr_vec), .pend_q(pend)
  );

  irq_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .req(pend & ~mask_vec), .hit(hit), .idx(hit_idx)
  );

  irq_msg_fsm #(.NUM_PINS(NUM_PINS)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .hit(hit), .hit_idx(hit_idx),
    .sel_fields(fields[hit_idx]), .ext_req(ext_req), .ext_ack(ext_ack),
    .ext_vector(ext_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg(msg), .clr_vec(clr_vec)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dmode;
  assign msg_deliv     = msg.deliv;
  assign msg_vector    = msg.vec;
  assign msg_polarity  = msg.pol;
  assign msg_level     = msg.lvl;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_int_n |=> (!msg_valid && !ext_req));
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int N = 24;
  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] lines;
  logic remap;
  logic [N-1:0][63:0] tbl;
  logic ext_req, ext_ack, msg_valid, msg_ready;
  logic [7:0] ext_vector, msg_dest, msg_vector;
  logic msg_dest_mode, msg_polarity, msg_level;
  logic [2:0] msg_deliv;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_dispatch #(.NUM_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .irq0_remap(remap),
    .route_tbl(tbl), .ext_req(ext_req), .ext_ack(ext_ack), .ext_vector(ext_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_level(msg_level)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [63:0] mk(logic [7:0] vec, logic [2:0] dm, logic dmode,
                                     logic pol, logic lvl, logic msk, logic [7:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmode; e[13] = pol;
    e[15] = lvl; e[16] = msk; e[63:56] = dest;
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cur();
    return {40'd0, msg_dest, msg_dest_mode, msg_deliv, msg_vector, msg_polarity, msg_level};
  endfunction

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 12; i++) begin
      if (msg_valid) begin got = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic expect_msg(string req, logic [63:0] e, int hold);
    bit got;
    logic [63:0] exp, first;
    exp = {40'd0, e[63:56], e[11], e[10:8], e[7:0], e[13], e[15]};
    wait_valid(got);
    chk(got, req, {63'd0, got}, 64'd1);
    first = cur();
    chk(first == exp, req, first, exp);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(msg_valid && cur() == first, {req, " hold R7"}, cur(), first);
    end
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_quiet(string req, int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid || ext_req) seen = 1;
    end
    chk(!seen, req, {63'd0, seen}, 64'd0);
  endtask

  task automatic pulse(logic [N-1:0] m);
    lines = lines | m;
    @(negedge clk);
    lines = lines & ~m;
  endtask

  task automatic mask_all();
    for (int i = 0; i < N; i++) tbl[i] = mk(8'h00, 3'd0, 0, 0, 0, 1, 8'h00);
  endtask

  initial begin
    logic [63:0] e;
    bit got;
    rst_n = 1'b0; lines = '0; remap = 1'b0; ext_ack = 1'b0; ext_vector = '0;
    msg_ready = 1'b0;
    mask_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!msg_valid && !ext_req, "R1 idle", {62'd0, msg_valid, ext_req}, 64'd0);
    for (int i = 0; i < N; i++) tbl[i] = mk(8'h10, 3'd0, 0, 0, 0, 0, 8'h01);
    expect_quiet("R1 pending clear", 5);

    // R7 R3 R5 sweep: every pin, edge, unmasked, distinct fields
    for (int p = 0; p < N; p++) begin
      mask_all();
      e = mk(8'h20 + 8'(p), 3'(p % 7), p[0], p[1], 1'b0, 1'b0, 8'hC0 + 8'(p));
      tbl[p] = e;
      @(negedge clk);
      pulse(N'(1) << p);
      expect_msg("R7 fields", e, (p % 4 == 0) ? 2 : 0);
      expect_quiet("R5 edge cleared", 4);
    end

    // R3 held high sets once
    mask_all();
    e = mk(8'h55, 3'd1, 1, 0, 0, 0, 8'h05);
    tbl[5] = e;
    @(negedge clk);
    lines[5] = 1'b1;
    expect_msg("R3 held", e, 0);
    expect_quiet("R3 held once", 6);
    lines[5] = 1'b0;
    expect_quiet("R3 fall no effect", 3);

    // R3 R4 falling does not clear; masked stays pending
    tbl[6] = mk(8'h66, 3'd0, 0, 1, 0, 1, 8'h06);
    @(negedge clk);
    pulse(N'(1) << 6);
    expect_quiet("R4 masked not sent", 4);
    e = mk(8'h66, 3'd0, 0, 1, 0, 0, 8'h06);
    tbl[6] = e;
    expect_msg("R4 unmask delivers", e, 1);
    expect_quiet("R5 after unmask", 4);

    // R2 level pin dropped while masked
    tbl[7] = mk(8'h77, 3'd2, 1, 1, 1, 1, 8'h07);
    lines[7] = 1'b1;
    repeat (3) @(negedge clk);
    lines[7] = 1'b0;
    repeat (2) @(negedge clk);
    tbl[7] = mk(8'h77, 3'd2, 1, 1, 1, 0, 8'h07);
    expect_quiet("R2 low clears", 4);

    // R2 R5 level high while masked, then unmask, then re-delivery
    tbl[7] = mk(8'h77, 3'd2, 1, 1, 1, 1, 8'h07);
    lines[7] = 1'b1;
    repeat (3) @(negedge clk);
    e = mk(8'h77, 3'd2, 1, 1, 1, 0, 8'h07);
    tbl[7] = e;
    expect_msg("R2 level delivered", e, 1);
    lines[7] = 1'b0;
    expect_msg("R5 level stays pending", e, 0);
    expect_quiet("R2 level cleared by low", 5);
    mask_all();

    // R8 ascending order
    @(negedge clk);
    pulse((N'(1) << 3) | (N'(1) << 9) | (N'(1) << 15));
    @(negedge clk);
    tbl[3]  = mk(8'h83, 3'd0, 0, 0, 0, 0, 8'h03);
    tbl[9]  = mk(8'h89, 3'd0, 0, 0, 0, 0, 8'h09);
    tbl[15] = mk(8'h8F, 3'd0, 0, 0, 0, 0, 8'h0F);
    expect_msg("R8 first", tbl[3], 0);
    expect_msg("R8 second", tbl[9], 0);
    expect_msg("R8 third", tbl[15], 0);
    expect_quiet("R8 done", 4);

    // R6 external vector fetch
    mask_all();
    tbl[10] = mk(8'h5A, 3'd7, 1, 0, 0, 0, 8'hA0);
    @(negedge clk);
    pulse(N'(1) << 10);
    got = 0;
    for (int i = 0; i < 8 && !got; i++) begin
      if (ext_req) got = 1; else @(negedge clk);
    end
    chk(got, "R6 ext_req raised", {63'd0, got}, 64'd1);
    chk(!msg_valid, "R6 no msg during fetch", {63'd0, msg_valid}, 64'd0);
    repeat (3) @(negedge clk);
    chk(ext_req && !msg_valid, "R6 req held", {62'd0, ext_req, msg_valid}, 64'd2);
    ext_vector = 8'hA7; ext_ack = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0; ext_vector = 8'h00;
    chk(!ext_req, "R6 req dropped", {63'd0, ext_req}, 64'd0);
    expect_msg("R6 fetched vector", mk(8'hA7, 3'd7, 1, 0, 0, 0, 8'hA0), 1);
    expect_quiet("R6 done", 4);

    // R9 line 0 override
    mask_all();
    tbl[0] = mk(8'h40, 3'd0, 0, 0, 0, 0, 8'h10);
    tbl[2] = mk(8'h42, 3'd0, 0, 0, 0, 0, 8'h12);
    remap = 1'b1;
    @(negedge clk);
    pulse(N'(1));
    expect_msg("R9 routed to pin 2", tbl[2], 0);
    expect_quiet("R9 pin 0 silent", 4);
    remap = 1'b0;
    @(negedge clk);
    pulse(N'(1));
    expect_msg("R9 direct to pin 0", tbl[0], 0);
    expect_quiet("R9 done", 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule